// File: doc/BRIEF.md
# Linked Descriptor Walker

This block walks a linked list of 16-byte scatter-gather descriptors held in local memory. It starts on a single start pulse that carries the address of the first descriptor. It reads each descriptor as four 32-bit words through a simple read port, one read in flight at a time. From the fields it decodes, it presents one transfer request to an external data mover.

The request carries the base address, the byte count (the stored length in 8-byte units, scaled up), the direction, an ordering hint and a 4-bit timing mode. The request stays up until the mover reports completion. Only then does the walker fetch the next descriptor, so it never has more than one transfer outstanding.

A flag bit marks the last entry, and the link word of that entry is never followed. The walk aborts with an error code in three cases: a zero length, a transfer that would wrap past the 4 GiB boundary, or a chain that grows past a parameterised entry limit without reaching a last entry.

Top module: `sgw_walker`

## Requirements
- R1: After reset, busy_o, mem_req_o, xfer_valid_o, done_o and err_o are all low, and err_code_o is 0.
- R2: The four words of a descriptor are read in order from the descriptor address plus 0, 4, 8 and 12. A new read is issued only after the previous read has returned.
- R3: A request presents word 0 as the address and word 1 times 8 as a 35-bit byte count. The direction is bit 5 of byte 0 of word 2 (1 = host to device) and the ordering hint is bit 4 of that byte. The mode is the low 4 bits of byte 1 of word 2.
- R4: xfer_valid_o and every request field stay constant until xfer_done_i. No descriptor read happens while a request is up.
- R5: Bit 7 of byte 0 of word 2 marks the last entry. Its completion ends the walk with a one-cycle done_o, and its link word (word 3) is never read through.
- R6: On completion of an entry that is not last, the next descriptor is fetched from the address in word 3.
- R7: A zero length field ends the walk with err_o and code 1, and no request is issued for that entry.
- R8: If the address plus the byte count exceeds 2^32, the walk ends with code 2 and no request. A transfer that ends exactly at 2^32 is accepted.
- R9: The MAX_DESC-th entry of a chain, if it is not last, ends the walk with code 3 and no request. The checks on that entry apply in the order R7, then R8, then R9.
- R10: start_i is ignored while busy_o is high.
- R11: done_o and err_o are single-cycle pulses that never coincide, and busy_o is low in the cycle they are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| start_addr_i | input | 32 | Byte address of the first descriptor |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Word read request, one cycle |
| mem_addr_o | output | 32 | Byte address of the word read |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 32 | Read data |
| xfer_valid_o | output | 1 | Transfer request pending |
| xfer_addr_o | output | 32 | Transfer base address |
| xfer_bytes_o | output | 35 | Transfer byte count |
| xfer_write_o | output | 1 | 1 = host to device |
| xfer_ordered_o | output | 1 | Ordering hint |
| xfer_mode_o | output | 4 | Timing mode |
| xfer_done_i | input | 1 | Transfer complete pulse |
| done_o | output | 1 | Chain finished |
| err_o | output | 1 | Chain aborted |
| err_code_o | output | 2 | 1 zero length, 2 boundary, 3 entry limit |

## Verification
The assertions assume two things about the surroundings. First, read data comes back only for a read that is actually pending. Second, the mover raises xfer_done_i only while a request is visible. The bench memory model answers each read exactly one cycle after the request and never otherwise. The mover model pulses completion for one cycle only after it has sampled xfer_valid_o high. The scenarios cover exact-fit and overflowing transfers at the top of the address space, a self-linked chain and a start pulse issued mid-walk.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int ADDR_W    = 32;
  localparam int WORD_W    = 32;
  localparam int DESC_WDS  = 4;
  localparam int LEN_SHIFT = 3;
  localparam int BYTES_W   = WORD_W + LEN_SHIFT;
  localparam int MODE_W    = 4;
  localparam int FLG_ORD   = 4;
  localparam int FLG_WR    = 5;
  localparam int FLG_LAST  = 7;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ZERO  = 2'd1,
    ERR_CROSS = 2'd2,
    ERR_LOOP  = 2'd3
  } err_e;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [BYTES_W-1:0] bytes;
    logic               write;
    logic               ordered;
    logic               last;
    logic [MODE_W-1:0]  mode;
    logic [ADDR_W-1:0]  next;
  } desc_t;
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int NW = DESC_WDS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic [ADDR_W-1:0]        base_i,
  output logic                     mem_req_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic                     mem_valid_i,
  input  logic [WORD_W-1:0]        mem_data_i,
  output logic [NW-1:0][WORD_W-1:0] words_o,
  output logic                     fetched_o
);
  localparam int CW  = (NW > 1) ? $clog2(NW) : 1;
  localparam int BSH = $clog2(WORD_W / 8);

  logic              active_q, pend_q, fetched_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              accept;

  assign accept     = mem_valid_i & pend_q;
  assign mem_req_o  = active_q & ~pend_q;
  assign mem_addr_o = base_q + (ADDR_W'(cnt_q) << BSH);
  assign fetched_o  = fetched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      pend_q    <= 1'b0;
      cnt_q     <= '0;
      base_q    <= '0;
      fetched_q <= 1'b0;
    end else begin
      fetched_q <= accept & (cnt_q == CW'(NW - 1));
      if (go_i) begin
        active_q <= 1'b1;
        pend_q   <= 1'b0;
        cnt_q    <= '0;
        base_q   <= base_i;
      end else begin
        if (mem_req_o) pend_q <= 1'b1;
        if (accept) begin
          pend_q <= 1'b0;
          if (cnt_q == CW'(NW - 1)) active_q <= 1'b0;
          else                      cnt_q    <= cnt_q + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             word_q <= '0;
      else if (accept && cnt_q == CW'(g))      word_q <= mem_data_i;
    end
    assign words_o[g] = word_q;
  end

  // R2: one read in flight
  a_r2_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r2_data_only_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i |-> pend_q);
endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
(
  input  logic [DESC_WDS-1:0][WORD_W-1:0] words_i,
  output desc_t                           desc_o,
  output err_e                            fault_o
);
  logic [7:0]         flags;
  logic [7:0]         mode_byte;
  logic [BYTES_W:0]   end_addr;
  localparam logic [BYTES_W:0] ADDR_SPAN = (BYTES_W+1)'(1) << ADDR_W;

  always_comb begin
    flags        = words_i[2][7:0];
    mode_byte    = words_i[2][15:8];
    desc_o.addr    = words_i[0];
    desc_o.bytes   = {words_i[1], {LEN_SHIFT{1'b0}}};
    desc_o.write   = flags[FLG_WR];
    desc_o.ordered = flags[FLG_ORD];
    desc_o.last    = flags[FLG_LAST];
    desc_o.mode    = mode_byte[MODE_W-1:0];
    desc_o.next    = words_i[3];
    end_addr     = (BYTES_W+1)'(words_i[0]) + (BYTES_W+1)'(desc_o.bytes);
    if (words_i[1] == '0)         fault_o = ERR_ZERO;
    else if (end_addr > ADDR_SPAN) fault_o = ERR_CROSS;
    else                          fault_o = ERR_NONE;
  end
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
#(
  parameter int MAX_DESC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  desc_t             desc_i,
  input  err_e              fault_i,
  input  logic              fetched_i,
  input  logic              xfer_done_i,
  output logic              fetch_go_o,
  output logic [ADDR_W-1:0] fetch_base_o,
  output logic              xfer_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);
  localparam int IW = (MAX_DESC > 2) ? $clog2(MAX_DESC) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_XFER} st_e;

  st_e           st_q;
  logic [IW-1:0] idx_q;
  logic          done_q, err_q;
  err_e          code_q;
  logic          advance;

  assign advance      = (st_q == ST_XFER) & xfer_done_i & ~desc_i.last;
  assign fetch_go_o   = ((st_q == ST_IDLE) & start_i) | advance;
  assign fetch_base_o = (st_q == ST_IDLE) ? start_addr_i : desc_i.next;
  assign xfer_valid_o = (st_q == ST_XFER);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign err_code_o   = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_FETCH;
          idx_q  <= '0;
          code_q <= ERR_NONE;
        end
        ST_FETCH: if (fetched_i) st_q <= ST_CHECK;
        ST_CHECK: begin
          if (fault_i != ERR_NONE) begin
            st_q <= ST_IDLE; err_q <= 1'b1; code_q <= fault_i;
          end else if (!desc_i.last && idx_q == IW'(MAX_DESC - 1)) begin
            st_q <= ST_IDLE; err_q <= 1'b1; code_q <= ERR_LOOP;
          end else begin
            st_q <= ST_XFER;
          end
        end
        ST_XFER: if (xfer_done_i) begin
          if (desc_i.last) begin
            st_q <= ST_IDLE; done_q <= 1'b1;
          end else begin
            st_q  <= ST_FETCH;
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4: request held until completion
  a_r4_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_done_i |=> xfer_valid_o);
  // R11: pulses exclusive and single-cycle
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_idle_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  // R9: entry index bounded
  a_r9_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(MAX_DESC - 1));
  // R10: start while busy does not restart
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !xfer_done_i |=> $stable(idx_q));
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int MAX_DESC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [31:0]   start_addr_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [31:0]   mem_data_i,
  output logic          xfer_valid_o,
  output logic [31:0]   xfer_addr_o,
  output logic [34:0]   xfer_bytes_o,
  output logic          xfer_write_o,
  output logic          xfer_ordered_o,
  output logic [3:0]    xfer_mode_o,
  input  logic          xfer_done_i,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    err_code_o
);
  logic [DESC_WDS-1:0][WORD_W-1:0] words;
  logic              fetched, fetch_go;
  logic [ADDR_W-1:0] fetch_base;
  desc_t             desc;
  err_e              fault;

  sgw_fetch #(.NW(DESC_WDS)) u_fetch (
    .clk_i, .rst_ni,
    .go_i(fetch_go), .base_i(fetch_base),
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_data_i,
    .words_o(words), .fetched_o(fetched)
  );

  sgw_decode u_dec (.words_i(words), .desc_o(desc), .fault_o(fault));

  sgw_ctrl #(.MAX_DESC(MAX_DESC)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .start_addr_i,
    .desc_i(desc), .fault_i(fault), .fetched_i(fetched),
    .xfer_done_i, .fetch_go_o(fetch_go), .fetch_base_o(fetch_base),
    .xfer_valid_o, .busy_o, .done_o, .err_o, .err_code_o
  );

  assign xfer_addr_o    = desc.addr;
  assign xfer_bytes_o   = desc.bytes;
  assign xfer_write_o   = desc.write;
  assign xfer_ordered_o = desc.ordered;
  assign xfer_mode_o    = desc.mode;

  // R4: no read while a request is up; fields stable
  a_r4_no_fetch_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> !mem_req_o);
  a_r4_fields_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_done_i |=> $stable(xfer_addr_o) && $stable(xfer_bytes_o)
      && $stable(xfer_mode_o) && $stable(xfer_write_o));
  // R7: never request zero bytes
  a_r7_no_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> xfer_bytes_o != '0);
  // R8: never cross the 4 GiB line
  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> ({4'b0, xfer_addr_o} + {1'b0, xfer_bytes_o}) <= 36'h1_0000_0000);
  // R1: quiet while idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !xfer_valid_o);
endmodule

// File: tb/sim_sgw_walker.sv
`timescale 1ns/1ps
module sim_sgw_walker;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic        busy_o, mem_req_o, mem_valid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_data_i = '0;
  logic        xfer_valid_o, xfer_write_o, xfer_ordered_o, xfer_done_i = 1'b0;
  logic [31:0] xfer_addr_o;
  logic [34:0] xfer_bytes_o;
  logic [3:0]  xfer_mode_o;
  logic        done_o, err_o;
  logic [1:0]  err_code_o;

  int checks = 0, errors = 0;
  int req_cnt = 0, xv_rise = 0;
  logic xv_d = 1'b0;
  logic [31:0] mem [64];

  always #2 clk = ~clk;

  sgw_walker #(.MAX_DESC(8)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .start_addr_i, .busy_o,
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_data_i,
    .xfer_valid_o, .xfer_addr_o, .xfer_bytes_o, .xfer_write_o,
    .xfer_ordered_o, .xfer_mode_o, .xfer_done_i,
    .done_o, .err_o, .err_code_o
  );

  // memory model: answers one cycle after each read
  always @(posedge clk) begin
    mem_valid_i <= mem_req_o;
    mem_data_i  <= mem_req_o ? mem[mem_addr_o[7:2]] : 32'h0;
    if (mem_req_o) req_cnt <= req_cnt + 1;
    xv_d <= xfer_valid_o;
    if (xfer_valid_o && !xv_d) xv_rise <= xv_rise + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int at, input logic [31:0] a, input logic [31:0] len,
                          input logic [7:0] flg, input logic [7:0] md, input logic [31:0] nxt);
    mem[at>>2]     = a;
    mem[(at>>2)+1] = len;
    mem[(at>>2)+2] = {8'h00, 8'h00, md, flg};
    mem[(at>>2)+3] = nxt;
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk); start_addr_i = a; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic expect_xfer(input string req, input logic [31:0] a, input logic [34:0] b,
                             input bit wr, input bit od, input logic [3:0] md);
    int n = 0;
    while (!xfer_valid_o && n < 1000) begin @(negedge clk); n++; end
    chk(xfer_valid_o, req, "request seen", 64'(xfer_valid_o), 64'd1);
    chk(xfer_addr_o == a, req, "addr", 64'(xfer_addr_o), 64'(a));
    chk(xfer_bytes_o == b, req, "bytes", 64'(xfer_bytes_o), 64'(b));
    chk({xfer_write_o, xfer_ordered_o} == {wr, od}, req, "dir/ord",
        64'({xfer_write_o, xfer_ordered_o}), 64'({wr, od}));
    chk(xfer_mode_o == md, req, "mode", 64'(xfer_mode_o), 64'(md));
    repeat (2) @(negedge clk);
    chk(xfer_valid_o && xfer_addr_o == a && !mem_req_o, "R4", "held until done",
        64'(xfer_addr_o), 64'(a));
    xfer_done_i = 1'b1;
    @(negedge clk); xfer_done_i = 1'b0;
  endtask

  task automatic expect_end(input string req, input bit is_err, input logic [1:0] code);
    int n = 0;
    while (!done_o && !err_o && n < 1000) begin @(negedge clk); n++; end
    chk(done_o == !is_err && err_o == is_err, req, "end kind",
        64'({done_o, err_o}), 64'({!is_err, is_err}));
    if (is_err) chk(err_code_o == code, req, "err code", 64'(err_code_o), 64'(code));
    chk(!busy_o, "R11", "idle at end", 64'(busy_o), 64'd0);
    @(negedge clk);
    chk(!done_o && !err_o, "R11", "single pulse", 64'({done_o, err_o}), 64'd0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !mem_req_o && !xfer_valid_o && !done_o && !err_o && err_code_o == 0,
        "R1", "reset outputs", 64'({busy_o, mem_req_o, xfer_valid_o, done_o, err_o, err_code_o}), 64'd0);
  endtask

  task automatic t_single;
    int r0;
    put_desc(8'h00, 32'h1000, 32'd4, 8'hB0, 8'h5A, 32'h0000_00C0);
    r0 = req_cnt;
    kick(32'h0);
    @(negedge clk); @(negedge clk);
    chk(mem_addr_o == 32'h4, "R2", "second word addr", 64'(mem_addr_o), 64'h4);
    expect_xfer("R3", 32'h1000, 35'd32, 1'b1, 1'b1, 4'hA);
    expect_end("R5", 1'b0, 2'd0);
    chk(req_cnt - r0 == 4, "R5", "reads for one entry", 64'(req_cnt - r0), 64'd4);
  endtask

  task automatic t_chain;
    int r0;
    put_desc(8'h00, 32'h2000, 32'd1,  8'h10, 8'h03, 32'h40);
    put_desc(8'h40, 32'h3000, 32'h10, 8'h20, 8'hF7, 32'h20);
    put_desc(8'h20, 32'h4000, 32'd8,  8'h80, 8'h01, 32'h80);
    r0 = req_cnt;
    kick(32'h0);
    expect_xfer("R6", 32'h2000, 35'd8,   1'b0, 1'b1, 4'h3);
    expect_xfer("R6", 32'h3000, 35'd128, 1'b1, 1'b0, 4'h7);
    expect_xfer("R6", 32'h4000, 35'd64,  1'b0, 1'b0, 4'h1);
    expect_end("R5", 1'b0, 2'd0);
    chk(req_cnt - r0 == 12, "R5", "no read past last", 64'(req_cnt - r0), 64'd12);
  endtask

  task automatic t_zero;
    int x0;
    put_desc(8'h00, 32'h5000, 32'd4, 8'h00, 8'h02, 32'h10);
    put_desc(8'h10, 32'h6000, 32'd0, 8'h80, 8'h02, 32'h0);
    x0 = xv_rise;
    kick(32'h0);
    expect_xfer("R7", 32'h5000, 35'd32, 1'b0, 1'b0, 4'h2);
    expect_end("R7", 1'b1, 2'd1);
    chk(xv_rise - x0 == 1, "R7", "no request for zero entry", 64'(xv_rise - x0), 64'd1);
  endtask

  task automatic t_bound;
    int x0;
    put_desc(8'h00, 32'hFFFF_FFF0, 32'd2, 8'h80, 8'h00, 32'h0);
    kick(32'h0);
    expect_xfer("R8", 32'hFFFF_FFF0, 35'd16, 1'b0, 1'b0, 4'h0);
    expect_end("R8", 1'b0, 2'd0);
    put_desc(8'h00, 32'h0, 32'h2000_0000, 8'h80, 8'h04, 32'h0);
    kick(32'h0);
    expect_xfer("R3", 32'h0, 35'h1_0000_0000, 1'b0, 1'b0, 4'h4);
    expect_end("R8", 1'b0, 2'd0);
    x0 = xv_rise;
    put_desc(8'h00, 32'hFFFF_FFF0, 32'd3, 8'h80, 8'h00, 32'h0);
    kick(32'h0);
    expect_end("R8", 1'b1, 2'd2);
    put_desc(8'h00, 32'h0, 32'hFFFF_FFFF, 8'h80, 8'h00, 32'h0);
    kick(32'h0);
    expect_end("R8", 1'b1, 2'd2);
    chk(xv_rise == x0, "R8", "no request on overflow", 64'(xv_rise - x0), 64'd0);
  endtask

  task automatic t_loop;
    int r0;
    put_desc(8'h60, 32'h7000, 32'd1, 8'h00, 8'h06, 32'h60);
    r0 = req_cnt;
    kick(32'h60);
    for (int i = 0; i < 7; i++) expect_xfer("R9", 32'h7000, 35'd8, 1'b0, 1'b0, 4'h6);
    expect_end("R9", 1'b1, 2'd3);
    chk(req_cnt - r0 == 32, "R9", "reads before abort", 64'(req_cnt - r0), 64'd32);
  endtask

  task automatic t_busy_start;
    put_desc(8'h00, 32'h8000, 32'd2, 8'h00, 8'h09, 32'h10);
    put_desc(8'h10, 32'h9000, 32'd3, 8'h80, 8'h09, 32'h0);
    put_desc(8'h80, 32'hDEAD_0000, 32'd1, 8'h80, 8'h00, 32'h0);
    kick(32'h0);
    kick(32'h80);
    expect_xfer("R10", 32'h8000, 35'd16, 1'b0, 1'b0, 4'h9);
    kick(32'h80);
    expect_xfer("R10", 32'h9000, 35'd24, 1'b0, 1'b0, 4'h9);
    expect_end("R10", 1'b0, 2'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_chain;
    t_zero;
    t_bound;
    t_loop;
    t_busy_start;
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule